// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised set of external interrupt lines and turns them into one request output per processor target. The number of lines is N = 8*(K+1), where K is a build parameter that is also reported in a read-only configuration word. Each line has its own sense settings: polarity, a level-or-edge trigger choice, and a both-edges option. Each line also has an enable (mask) bit, a pin-map entry with an enable flag and a pin number, and a one-hot target selection. Every input passes through a two-flop synchroniser. In level mode the line's pending state follows the qualified input. In edge mode the detected edges are latched until software acknowledges them.

Software uses a plain word-addressed write/read port. The address is split into a 4-bit region (addr[11:8]) and an 8-bit index (addr[7:0]). Enables are changed through dedicated set and clear ports that take a source number in the write data. A single trigger register raises or acknowledges a line's latched edge state, and bit 31 selects which. The raw pending vector is available both on a port and as 32-bit read words.

Top module: `sic_top`

## Requirements
- R1: After reset every source reads back polarity 1 (active high) in region 1, trigger 0 (level) in region 2, both-edges 0 in region 3, enable 0 in region 4, and 0 in the pin-map (region 5) and target-map (region 6) entries. All request outputs are 0.
- R2: Reading region 0 index 0 returns the configuration word. Bits [7:0] hold K and bits [15:8] hold the target count. The source count is (K+1)*8.
- R3: A write to region 0 index 1 enables the source whose number is in wrData[7:0]. A write to index 2 disables it. Region 4 reads the enable bit in bit 0. A source number >= N is ignored and is never truncated onto another source.
- R4: With trigger 0 (level), a source's pending bit equals its synchronised input when polarity is 1, and its inverse when polarity is 0. The bit drops as soon as the input returns inactive.
- R5: With trigger 1 (edge) and both-edges 0, a rising input edge (polarity 1) or a falling input edge (polarity 0) sets a latched pending bit. The opposite edge does not set it, and the bit stays set after the input returns.
- R6: With trigger 1 and both-edges 1, either input edge sets the latched pending bit, whatever the polarity.
- R7: A write to region 0 index 3 with wrData[31]=1 sets the latched pending bit of source wrData[7:0]. With wrData[31]=0 the same write clears it (acknowledge). A source number >= N is ignored.
- R8: The target map (region 6, bits [T-1:0]) holds at most one set bit. A write with several bits set keeps only the lowest one, and zero routes the source to no target.
- R9: The pin-map entry (region 5) keeps an enable flag in bit 31 and a pin number in bits [PIN_W-1:0]. Other bits read as 0. A source reaches no target while the flag is 0.
- R10: Request output t is the OR, over all sources, of pending AND enabled AND pin-map flag AND target-map bit t.
- R11: The pending vector is driven on pendVec. It can also be read at region 0 index 8+w, where bit b is source 32*w+b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIn | input | N | Raw external interrupt lines |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Write address: region [11:8], index [7:0] |
| wrData | input | 32 | Write data |
| rdAddr | input | 12 | Read address: region [11:8], index [7:0] |
| rdData | output | 32 | Read data, combinational from rdAddr |
| irqOut | output | T | One request per target |
| pendVec | output | N | Raw pending state of every source |
| cfgWord | output | 32 | Read-only configuration word |

## Verification
The embedded properties assume that each write is a single-cycle pulse. They also assume that a set-enable, clear-enable or trigger write names exactly one source, so no two control strobes for one source fall in the same cycle. The bench meets this by driving every register write through one task that raises wrEn for one clock and leaves at least one idle cycle before the next write. After each input change on srcIn, the bench waits four clocks so the synchroniser and edge detector have settled before it samples pending or request outputs.

// File: rtl/sic_pkg.sv
`timescale 1ns/1ps
package sic_pkg;
  localparam logic [3:0] RG_GLOBAL = 4'd0;
  localparam logic [3:0] RG_POL    = 4'd1;
  localparam logic [3:0] RG_TRIG   = 4'd2;
  localparam logic [3:0] RG_DUAL   = 4'd3;
  localparam logic [3:0] RG_MASK   = 4'd4;
  localparam logic [3:0] RG_PIN    = 4'd5;
  localparam logic [3:0] RG_MAP    = 4'd6;

  localparam logic [7:0] GI_CFG    = 8'd0;
  localparam logic [7:0] GI_SETEN  = 8'd1;
  localparam logic [7:0] GI_CLREN  = 8'd2;
  localparam logic [7:0] GI_TRIGGR = 8'd3;
  localparam int         GI_PEND0  = 8;

  typedef struct packed {
    logic        setMask;
    logic        clrMask;
    logic        wedgeSet;
    logic        wedgeClr;
    logic        wrPol;
    logic        wrTrig;
    logic        wrDual;
    logic        wrPin;
    logic        wrMap;
    logic [7:0]  idx;
    logic [31:0] data;
  } sicStrobe_t;
endpackage

// File: rtl/sic_ctrl.sv
`timescale 1ns/1ps
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int N = 32
) (
  input  logic        wrEn,
  input  logic [11:0] wrAddr,
  input  logic [31:0] wrData,
  output sicStrobe_t  st
);
  logic [3:0] region;
  logic [7:0] dataIdx;
  logic [7:0] addrIdx;
  logic       dataOk;
  logic       addrOk;

  assign region  = wrAddr[11:8];
  assign addrIdx = wrAddr[7:0];
  assign dataIdx = wrData[7:0];
  assign dataOk  = ({1'b0, dataIdx} < 9'(N));
  assign addrOk  = ({1'b0, addrIdx} < 9'(N));

  always_comb begin
    st      = '0;
    st.data = wrData;
    st.idx  = (region == RG_GLOBAL) ? dataIdx : addrIdx;
    if (wrEn) begin
      unique case (region)
        RG_GLOBAL: begin
          if (addrIdx == GI_SETEN)  st.setMask = dataOk;
          if (addrIdx == GI_CLREN)  st.clrMask = dataOk;
          if (addrIdx == GI_TRIGGR) begin
            st.wedgeSet = dataOk &  wrData[31];
            st.wedgeClr = dataOk & ~wrData[31];
          end
        end
        RG_POL:  st.wrPol  = addrOk;
        RG_TRIG: st.wrTrig = addrOk;
        RG_DUAL: st.wrDual = addrOk;
        RG_PIN:  st.wrPin  = addrOk;
        RG_MAP:  st.wrMap  = addrOk;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sic_datapath.sv
`timescale 1ns/1ps
module sic_datapath
  import sic_pkg::*;
#(
  parameter int N     = 32,
  parameter int NT    = 4,
  parameter int PIN_W = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  sicStrobe_t    st,
  input  logic [N-1:0]  srcIn,
  input  logic [11:0]   rdAddr,
  input  logic [31:0]   cfgWord,
  output logic [31:0]   rdData,
  output logic [NT-1:0] irqOut,
  output logic [N-1:0]  pendVec,
  output logic [N-1:0]  maskVec
);
  localparam int W = (N + 31) / 32;

  logic [N-1:0] sync1, sync2, prevIn;
  logic [N-1:0] pol, trig, dual, edgeP, pinEn, edgeHit, eligible;
  logic [PIN_W-1:0] pinNum [N];
  logic [NT-1:0]    mapArr [N];
  logic [NT-1:0]    mapWr;
  logic [NT-1:0]    mapLow;
  logic [W*32-1:0]  pendPad;

  assign mapWr  = st.data[NT-1:0];
  assign mapLow = mapWr & (~mapWr + NT'(1));

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic riseE, fallE;
      riseE = sync2[i] & ~prevIn[i];
      fallE = ~sync2[i] & prevIn[i];
      edgeHit[i]  = trig[i] & (dual[i] ? (riseE | fallE) : (pol[i] ? riseE : fallE));
      pendVec[i]  = trig[i] ? edgeP[i] : ~(sync2[i] ^ pol[i]);
      eligible[i] = pendVec[i] & maskVec[i] & pinEn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= '0; sync2 <= '0; prevIn <= '0;
      pol <= '1; trig <= '0; dual <= '0; maskVec <= '0; edgeP <= '0; pinEn <= '0;
      for (int i = 0; i < N; i++) begin
        pinNum[i] <= '0;
        mapArr[i] <= '0;
      end
    end else begin
      sync1  <= srcIn;
      sync2  <= sync1;
      prevIn <= sync2;
      for (int i = 0; i < N; i++) begin
        if (st.idx == 8'(i)) begin
          if (st.setMask) maskVec[i] <= 1'b1;
          if (st.clrMask) maskVec[i] <= 1'b0;
          if (st.wrPol)   pol[i]     <= st.data[0];
          if (st.wrTrig)  trig[i]    <= st.data[0];
          if (st.wrDual)  dual[i]    <= st.data[0];
          if (st.wrPin) begin
            pinEn[i]  <= st.data[31];
            pinNum[i] <= st.data[PIN_W-1:0];
          end
          if (st.wrMap)   mapArr[i]  <= mapLow;
        end
        if (edgeHit[i] || (st.wedgeSet && st.idx == 8'(i)))
          edgeP[i] <= 1'b1;
        else if (st.wedgeClr && st.idx == 8'(i))
          edgeP[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    irqOut = '0;
    for (int i = 0; i < N; i++)
      for (int t = 0; t < NT; t++)
        irqOut[t] = irqOut[t] | (eligible[i] & mapArr[i][t]);
  end

  always_comb begin
    pendPad          = '0;
    pendPad[N-1:0]   = pendVec;
  end

  always_comb begin
    rdData = '0;
    if (rdAddr[11:8] == RG_GLOBAL) begin
      if (rdAddr[7:0] == GI_CFG) rdData = cfgWord;
      for (int w = 0; w < W; w++)
        if (rdAddr[7:0] == 8'(GI_PEND0 + w)) rdData = pendPad[w*32 +: 32];
    end else begin
      for (int i = 0; i < N; i++) begin
        if (rdAddr[7:0] == 8'(i)) begin
          unique case (rdAddr[11:8])
            RG_POL:  rdData[0] = pol[i];
            RG_TRIG: rdData[0] = trig[i];
            RG_DUAL: rdData[0] = dual[i];
            RG_MASK: rdData[0] = maskVec[i];
            RG_PIN: begin
              rdData[31]        = pinEn[i];
              rdData[PIN_W-1:0] = pinNum[i];
            end
            RG_MAP:  rdData[NT-1:0] = mapArr[i];
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      (st.setMask && st.idx == 8'(i)) |=> maskVec[i]);
    assert_enable_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
      (st.clrMask && st.idx == 8'(i)) |=> !maskVec[i]);
    assert_trigger_raise_R7: assert property (@(posedge clk) disable iff (!rstN)
      (st.wedgeSet && st.idx == 8'(i)) |=> edgeP[i]);
    assert_single_target_R8: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(mapArr[i]));
  end
endmodule

// File: rtl/sic_top.sv
`timescale 1ns/1ps
module sic_top
  import sic_pkg::*;
#(
  parameter int CFG_K = 3,
  parameter int NT    = 4,
  parameter int PIN_W = 6,
  localparam int N    = 8 * (CFG_K + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  srcIn,
  input  logic          wrEn,
  input  logic [11:0]   wrAddr,
  input  logic [31:0]   wrData,
  input  logic [11:0]   rdAddr,
  output logic [31:0]   rdData,
  output logic [NT-1:0] irqOut,
  output logic [N-1:0]  pendVec,
  output logic [31:0]   cfgWord
);
  sicStrobe_t   st;
  logic [N-1:0] maskVec;

  assign cfgWord = {16'h0, 8'(NT), 8'(CFG_K)};

  sic_ctrl #(.N(N)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .st(st)
  );

  sic_datapath #(.N(N), .NT(NT), .PIN_W(PIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .srcIn(srcIn), .rdAddr(rdAddr),
    .cfgWord(cfgWord), .rdData(rdData), .irqOut(irqOut),
    .pendVec(pendVec), .maskVec(maskVec)
  );

  assert_quiet_when_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> (irqOut == '0));
endmodule

// File: tb/test_sic_top.sv
`timescale 1ns/1ps
module test_sic_top;
  localparam int K = 3, N = 32, NT = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0]  srcIn = '0;
  logic          wrEn = 1'b0;
  logic [11:0]   wrAddr = '0, rdAddr = '0;
  logic [31:0]   wrData = '0, rdData, cfgWord;
  logic [NT-1:0] irqOut;
  logic [N-1:0]  pendVec;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sic_top #(.CFG_K(K), .NT(NT), .PIN_W(6)) i_sic_top (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut),
    .pendVec(pendVec), .cfgWord(cfgWord)
  );

  function automatic logic [11:0] ad(int region, int idx);
    return {4'(region), 8'(idx)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irqOut", 32'(irqOut), 0);
    chk("R1 pendVec", pendVec, 0);
    rd(ad(1, 7), d);  chk("R1 polarity", d, 1);
    rd(ad(2, 7), d);  chk("R1 trigger", d, 0);
    rd(ad(3, 7), d);  chk("R1 both-edges", d, 0);
    rd(ad(4, 7), d);  chk("R1 enable", d, 0);
    rd(ad(5, 7), d);  chk("R1 pin-map", d, 0);
    rd(ad(6, 7), d);  chk("R1 target-map", d, 0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    rd(ad(0, 0), d);
    chk("R2 config word", d, 32'h0000_0403);
    chk("R2 cfgWord port", cfgWord, 32'h0000_0403);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(ad(0, 1), 5);
    rd(ad(4, 5), d);  chk("R3 enable set", d, 1);
    wr(ad(0, 2), 5);
    rd(ad(4, 5), d);  chk("R3 enable clear", d, 0);
    wr(ad(0, 1), 40);
    rd(ad(4, 8), d);  chk("R3 out-of-range ignored", d, 0);
  endtask

  task automatic t_level();
    srcIn[3] = 1'b1; settle();
    chk("R4 level high active", 32'(pendVec[3]), 1);
    srcIn[3] = 1'b0; settle();
    chk("R4 level high drops", 32'(pendVec[3]), 0);
    wr(ad(1, 3), 0); settle();
    chk("R4 level low active", 32'(pendVec[3]), 1);
    srcIn[3] = 1'b1; settle();
    chk("R4 level low idle", 32'(pendVec[3]), 0);
    srcIn[3] = 1'b0;
    wr(ad(1, 3), 1); settle();
  endtask

  task automatic t_edge();
    wr(ad(2, 4), 1);
    srcIn[4] = 1'b1; settle();
    chk("R5 rising latched", 32'(pendVec[4]), 1);
    srcIn[4] = 1'b0; settle();
    chk("R5 rising held", 32'(pendVec[4]), 1);
    wr(ad(0, 3), 4);
    chk("R7 acknowledge", 32'(pendVec[4]), 0);
    wr(ad(1, 4), 0);
    srcIn[4] = 1'b1; settle();
    chk("R5 falling ignores rise", 32'(pendVec[4]), 0);
    srcIn[4] = 1'b0; settle();
    chk("R5 falling latched", 32'(pendVec[4]), 1);
    wr(ad(0, 3), 4);
    wr(ad(1, 4), 1);
  endtask

  task automatic t_dual();
    wr(ad(2, 6), 1); wr(ad(3, 6), 1); wr(ad(1, 6), 0);
    srcIn[6] = 1'b1; settle();
    chk("R6 rise with polarity 0", 32'(pendVec[6]), 1);
    wr(ad(0, 3), 6);
    chk("R6 ack", 32'(pendVec[6]), 0);
    srcIn[6] = 1'b0; settle();
    chk("R6 fall latched", 32'(pendVec[6]), 1);
    wr(ad(0, 3), 6);
  endtask

  task automatic t_wedge();
    logic [31:0] d;
    wr(ad(2, 10), 1);
    wr(ad(0, 3), 32'h8000_000A);
    chk("R7 raise", 32'(pendVec[10]), 1);
    rd(ad(0, 8), d);
    chk("R11 pending word", d, 32'h0000_0400);
    wr(ad(0, 3), 32'h0000_000A);
    chk("R7 clear", 32'(pendVec[10]), 0);
    wr(ad(0, 3), 32'h8000_002A);
    chk("R7 out-of-range raise ignored", 32'(pendVec[10]), 0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(ad(0, 3), 32'h8000_0004);
    wr(ad(0, 1), 4);
    wr(ad(5, 4), 32'h8000_0003);
    wr(ad(6, 4), 4'b0100);
    chk("R10 routed to target 2", 32'(irqOut), 32'h4);
    wr(ad(6, 4), 4'b0110);
    rd(ad(6, 4), d);
    chk("R8 lowest bit kept", d, 32'h2);
    chk("R10 routed to target 1", 32'(irqOut), 32'h2);
    wr(ad(5, 4), 32'h0000_0003);
    chk("R9 flag clear blocks", 32'(irqOut), 0);
    wr(ad(5, 4), 32'hFFFF_FFFF);
    rd(ad(5, 4), d);
    chk("R9 pin-map readback", d, 32'h8000_003F);
    wr(ad(0, 2), 4);
    chk("R10 disabled blocks", 32'(irqOut), 0);
    wr(ad(0, 1), 4);
    wr(ad(6, 4), 0);
    chk("R8 zero map routes nowhere", 32'(irqOut), 0);
    wr(ad(6, 4), 4'b0001);
    wr(ad(0, 1), 3); wr(ad(5, 3), 32'h8000_0000); wr(ad(6, 3), 4'b0001);
    srcIn[3] = 1'b1; settle();
    wr(ad(0, 3), 4);
    chk("R10 OR keeps level source", 32'(irqOut), 32'h1);
    srcIn[3] = 1'b0; settle();
    chk("R10 all sources idle", 32'(irqOut), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_mask();
    t_level();
    t_edge();
    t_dual();
    t_wedge();
    t_route();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule